// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of a byte-wide parallel flash. It takes one request at a time: program a byte, erase a sector, erase the whole chip, or reset the device to read mode. It then issues the bus write cycles that the flash needs for that command. These are the fixed unlock writes to addresses 5555h and 2AAAh, followed by the command byte and, where the command needs it, the target address and data. After the writes it reads the target location until the device reports that its internal operation has finished, or until a per-operation cycle budget runs out. The result comes back as a single done pulse, which carries error and timeout flags.

Bus cycles are abstract. The block raises either `mem_wr` or `mem_rd` together with the address and write data, and holds all of them unchanged until the memory side answers with `mem_ready`. Read data is taken in the cycle where `mem_ready` is high. The `req_toggle` input picks the completion method for each request. With it low, the block uses data polling: it compares bit 7 of each read with bit 7 of the expected byte. With it high, the block uses the toggle method: it compares bit 6 of one read with bit 6 of the read before it.

The controller has these states:

- `ST_IDLE`: waiting for a request.
- `ST_CMD`: issuing write step `step_q`.
- `ST_POLL`: data-polling reads.
- `ST_TOG_A`: the first toggle read.
- `ST_TOG_B`: the following toggle reads.
- `ST_VERIFY`: a final full-byte read after a program.
- `ST_DONE`: the one-cycle result.

It moves between them as follows:

- A request moves `ST_IDLE` to `ST_CMD`.
- In `ST_CMD`, each accepted write advances the step. After the last write, the block goes to `ST_DONE` for a reset, to `ST_POLL` when polling, and to `ST_TOG_A` when using the toggle method.
- In `ST_POLL`, a bit-7 match goes to `ST_VERIFY` for a program and to `ST_DONE` for an erase.
- `ST_TOG_A` always goes to `ST_TOG_B`.
- `ST_TOG_B` goes to `ST_DONE` once bit 6 stays the same.
- From any of the three wait states, an expired budget goes to `ST_DONE`.
- `ST_VERIFY` goes to `ST_DONE`.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `flash_seq`

## Requirements
- R1: Opcode 0 (program) issues exactly four writes, in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R2: Opcode 1 (sector erase) issues exactly six writes, in this order: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then the request address with 30h.
- R3: Opcode 2 (chip erase) issues the same first five writes as a sector erase, and its sixth write is 5555h/10h.
- R4: Opcode 3 (reset) issues one write of F0h to the request address, makes no reads, and then pulses done with no flags set.
- R5: With `req_toggle` low, the block keeps reading the request address until bit 7 of the read data equals bit 7 of the expected byte. The expected byte is the request data for a program and FFh for either erase.
- R6: With `req_toggle` high, the block finishes once two successive reads of the request address return the same bit 6. Bit 7 plays no part in this decision.
- R7: After a program in polling mode, one more read compares all 8 bits with the request data. `rsp_error` is high with done exactly when that compare fails.
- R8: When no completion is seen, the wait ends with done and `rsp_timeout` high. The budget is counted in wait cycles, and its limit is `T_PROG`, `T_SECT` or `T_CHIP` according to the opcode.
- R9: A request is taken only while `req_ready` is high. Requests presented while the block is busy are dropped and cause no bus activity.
- R10: After reset, `busy`, `rsp_done`, `mem_wr` and `mem_rd` are low and `req_ready` is high. `busy` stays high from the acceptance of a request through the cycle in which `rsp_done` pulses. `rsp_done` is high for exactly one cycle.
- R11: `mem_wr` and `mem_rd` are never high together. A raised write keeps its address and data unchanged until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken this cycle if valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reset |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| req_toggle | input | 1 | 1 selects toggle method, 0 data polling |
| busy | output | 1 | Request in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Verify mismatch, valid with done |
| rsp_timeout | output | 1 | Budget expired, valid with done |
| mem_wr | output | 1 | Bus write request |
| mem_rd | output | 1 | Bus read request |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Memory side completes the current request |

## Verification
The bench logs every write the memory side accepts. A wrong step table or a chip-erase/sector-erase mix-up therefore shows as a wrong entry or a wrong count in that log.

A memory model stays busy for a set number of reads and is then replaced by a model that never finishes. This exposes a poller that stops on the first read, one that looks at bit 6 while in polling mode, and one that keeps the wrong per-operation budget. The budget error shows as a done pulse outside the expected cycle window.

A stored value that differs from the programmed byte only in bit 0 catches a verify that checks bit 7 alone. A request pulsed while the block is busy catches an acceptance gate that fails to hold, because it shows up as an extra F0h write.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RST  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_POLL,
        ST_TOG_A,
        ST_TOG_B,
        ST_VERIFY,
        ST_DONE
    } state_e;

    localparam logic [15:0] UNLOCK_A = 16'h5555;
    localparam logic [15:0] UNLOCK_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A    = 8'hAA;
    localparam logic [7:0]  KEY_B    = 8'h55;
    localparam logic [7:0]  CMD_PGM  = 8'hA0;
    localparam logic [7:0]  CMD_ERS  = 8'h80;
    localparam logic [7:0]  CMD_CHIP = 8'h10;
    localparam logic [7:0]  CMD_SECT = 8'h30;
    localparam logic [7:0]  CMD_RST  = 8'hF0;

endpackage

// File: rtl/flash_seq_cmdgen.sv
module flash_seq_cmdgen
    import flash_seq_pkg::*;
#(
    parameter int AW = 19
) (
    input  op_e           op,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          last
);
    localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_A);
    localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_B);

    always_comb begin
        wr_addr = ADDR_A;
        wr_data = KEY_A;
        last    = 1'b0;
        unique case (op)
            OP_RST: begin
                wr_addr = tgt_addr;
                wr_data = CMD_RST;
                last    = 1'b1;
            end
            OP_PROG: begin
                unique case (step)
                    3'd0:    begin wr_addr = ADDR_A; wr_data = KEY_A; end
                    3'd1:    begin wr_addr = ADDR_B; wr_data = KEY_B; end
                    3'd2:    begin wr_addr = ADDR_A; wr_data = CMD_PGM; end
                    default: begin wr_addr = tgt_addr; wr_data = tgt_data; last = 1'b1; end
                endcase
            end
            default: begin
                unique case (step)
                    3'd0, 3'd3: begin wr_addr = ADDR_A; wr_data = KEY_A; end
                    3'd1, 3'd4: begin wr_addr = ADDR_B; wr_data = KEY_B; end
                    3'd2:       begin wr_addr = ADDR_A; wr_data = CMD_ERS; end
                    default: begin
                        last = 1'b1;
                        if (op == OP_CHIP) begin
                            wr_addr = ADDR_A;
                            wr_data = CMD_CHIP;
                        end else begin
                            wr_addr = tgt_addr;
                            wr_data = CMD_SECT;
                        end
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q < limit) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status (
    input  logic [7:0] rdata,
    input  logic [7:0] expect_byte,
    input  logic       prev_b6,
    output logic       poll_hit,
    output logic       tog_still,
    output logic       full_match
);
    assign poll_hit   = (rdata[7] == expect_byte[7]);
    assign tog_still  = (rdata[6] == prev_b6);
    assign full_match = (rdata == expect_byte);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW     = 19,
    parameter int TW     = 32,
    parameter int T_PROG = 1750,
    parameter int T_SECT = 500000,
    parameter int T_CHIP = 150000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          req_toggle,
    output logic          busy,
    output logic          rsp_done,
    output logic          rsp_error,
    output logic          rsp_timeout,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          mem_ready
);
    localparam logic [TW-1:0] LIM_PROG = TW'(T_PROG);
    localparam logic [TW-1:0] LIM_SECT = TW'(T_SECT);
    localparam logic [TW-1:0] LIM_CHIP = TW'(T_CHIP);

    state_e        state_q, state_d;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          tog_q;
    logic [2:0]    step_q;
    logic          prev6_q;
    logic          err_q, to_q;

    logic [AW-1:0] cmd_addr;
    logic [7:0]    cmd_data;
    logic          cmd_last;
    logic [7:0]    exp_byte;
    logic          poll_hit, tog_still, full_match;
    logic          waiting, expired;
    logic [TW-1:0] limit;

    flash_seq_cmdgen #(.AW(AW)) u_cmd (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (cmd_addr),
        .wr_data  (cmd_data),
        .last     (cmd_last)
    );

    assign exp_byte = (op_q == OP_PROG) ? data_q : 8'hFF;

    flash_seq_status u_stat (
        .rdata       (mem_rdata),
        .expect_byte (exp_byte),
        .prev_b6     (prev6_q),
        .poll_hit    (poll_hit),
        .tog_still   (tog_still),
        .full_match  (full_match)
    );

    always_comb begin
        unique case (op_q)
            OP_PROG: limit = LIM_PROG;
            OP_SECT: limit = LIM_SECT;
            default: limit = LIM_CHIP;
        endcase
    end

    assign waiting = (state_q == ST_POLL) || (state_q == ST_TOG_A) || (state_q == ST_TOG_B);

    flash_seq_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .limit   (limit),
        .expired (expired)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CMD;
            ST_CMD: begin
                if (mem_ready && cmd_last) begin
                    if (op_q == OP_RST)  state_d = ST_DONE;
                    else if (tog_q)      state_d = ST_TOG_A;
                    else                 state_d = ST_POLL;
                end
            end
            ST_POLL: begin
                if (mem_ready && poll_hit)
                    state_d = (op_q == OP_PROG) ? ST_VERIFY : ST_DONE;
                else if (expired)
                    state_d = ST_DONE;
            end
            ST_TOG_A: begin
                if (mem_ready)    state_d = ST_TOG_B;
                else if (expired) state_d = ST_DONE;
            end
            ST_TOG_B: begin
                if (mem_ready && tog_still) state_d = ST_DONE;
                else if (expired)           state_d = ST_DONE;
            end
            ST_VERIFY: if (mem_ready) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_RST;
            addr_q  <= '0;
            data_q  <= '0;
            tog_q   <= 1'b0;
            step_q  <= '0;
            prev6_q <= 1'b0;
            err_q   <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= op_e'(req_op);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        tog_q  <= req_toggle;
                        step_q <= '0;
                        err_q  <= 1'b0;
                        to_q   <= 1'b0;
                    end
                end
                ST_CMD: begin
                    if (mem_ready && !cmd_last) step_q <= step_q + 1'b1;
                end
                ST_POLL: begin
                    if (!(mem_ready && poll_hit) && expired) to_q <= 1'b1;
                end
                ST_TOG_A: begin
                    if (mem_ready)    prev6_q <= mem_rdata[6];
                    else if (expired) to_q <= 1'b1;
                end
                ST_TOG_B: begin
                    if (mem_ready) prev6_q <= mem_rdata[6];
                    if (!(mem_ready && tog_still) && expired) to_q <= 1'b1;
                end
                ST_VERIFY: begin
                    if (mem_ready) err_q <= !full_match;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        busy        = (state_q != ST_IDLE);
        rsp_done    = (state_q == ST_DONE);
        rsp_error   = rsp_done && err_q;
        rsp_timeout = rsp_done && to_q;
        mem_wr      = (state_q == ST_CMD);
        mem_rd      = waiting || (state_q == ST_VERIFY);
        mem_addr    = mem_wr ? cmd_addr : addr_q;
        mem_wdata   = mem_wr ? cmd_data : 8'h00;
    end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rsp_done,
    input logic          rsp_error,
    input logic          rsp_timeout,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          mem_ready
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done); // R10
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |-> busy); // R10
    AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(rsp_done)); // R10
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr)); // R11
    AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R11
    AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) rsp_timeout |-> rsp_done); // R8
    AST_ERROR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) rsp_error |-> (rsp_done && !rsp_timeout)); // R7
endmodule

bind flash_seq flash_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .rsp_done    (rsp_done),
    .rsp_error   (rsp_error),
    .rsp_timeout (rsp_timeout),
    .mem_wr      (mem_wr),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_ready   (mem_ready)
);

// File: tb/flash_seq_test.sv
module flash_seq_test;
    localparam int AW = 19;
    localparam int TP = 40;
    localparam int TS = 60;
    localparam int TC = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = 8'h00;
    logic          req_toggle = 1'b0;
    logic          busy, rsp_done, rsp_error, rsp_timeout;
    logic          mem_wr, mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = 8'h00;
    logic          mem_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // memory model state
    int            busy_left = 0;
    logic          stuck = 1'b0;
    logic [7:0]    final_val = 8'hFF;
    logic          tog_bit = 1'b0;
    logic [AW-1:0] wl_a [0:15];
    logic [7:0]    wl_d [0:15];
    int            wr_cnt = 0;
    int            rd_cnt = 0;
    logic [AW-1:0] rd_last = '0;
    logic          rd_addr_ok = 1'b1;

    always #10 clk = ~clk;

    flash_seq #(.AW(AW), .TW(16), .T_PROG(TP), .T_SECT(TS), .T_CHIP(TC)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
        .busy(busy), .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_timeout(rsp_timeout),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory-side responder: answers each request after one wait cycle
    always @(posedge clk) begin
        if (mem_wr && mem_ready) begin
            if (wr_cnt < 16) begin
                wl_a[wr_cnt] <= mem_addr;
                wl_d[wr_cnt] <= mem_wdata;
            end
            wr_cnt <= wr_cnt + 1;
        end
        mem_ready <= (mem_rd || mem_wr) && !mem_ready;
        if (mem_rd && !mem_ready) begin
            rd_cnt  <= rd_cnt + 1;
            rd_last <= mem_addr;
            if (busy_left > 0 || stuck) begin
                mem_rdata <= {~final_val[7], tog_bit, final_val[5:0]};
                tog_bit   <= ~tog_bit;
                if (busy_left > 0) busy_left <= busy_left - 1;
            end else begin
                mem_rdata <= final_val;
            end
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_setup(input int nbusy, input logic hang, input logic [7:0] fin);
        @(negedge clk);
        busy_left = nbusy;
        stuck     = hang;
        final_val = fin;
        tog_bit   = 1'b0;
        wr_cnt    = 0;
        rd_cnt    = 0;
    endtask

    // issue one request and wait for done; returns cycles from acceptance
    task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                           input logic tg, output int cyc, output logic err, output logic to);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_toggle = tg;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        err = rsp_error;
        to  = rsp_timeout;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        check(!busy && req_ready, "R10", "idle after reset", {busy, req_ready}, 2'b01);
        check(!mem_wr && !mem_rd && !rsp_done, "R10", "bus quiet after reset",
              {mem_wr, mem_rd, rsp_done}, 0);
    endtask

    task automatic t_program_poll;
        int c; logic e, t;
        model_setup(3, 1'b0, 8'h5A);
        run_req(2'd0, 19'h12345, 8'h5A, 1'b0, c, e, t);
        check(wr_cnt == 4, "R1", "program write count", wr_cnt, 4);
        check(wl_a[0] == 19'h05555 && wl_d[0] == 8'hAA, "R1", "program step0", wl_d[0], 8'hAA);
        check(wl_a[1] == 19'h02AAA && wl_d[1] == 8'h55, "R1", "program step1", wl_d[1], 8'h55);
        check(wl_a[2] == 19'h05555 && wl_d[2] == 8'hA0, "R1", "program step2", wl_d[2], 8'hA0);
        check(wl_a[3] == 19'h12345 && wl_d[3] == 8'h5A, "R1", "program data write", wl_a[3], 19'h12345);
        check(rd_cnt == 5, "R5", "polling reads then verify", rd_cnt, 5);
        check(rd_last == 19'h12345, "R5", "poll address", rd_last, 19'h12345);
        check(!e && !t, "R7", "clean program flags", {e, t}, 0);
    endtask

    task automatic t_program_verify_fail;
        int c; logic e, t;
        model_setup(2, 1'b0, 8'h5B);
        run_req(2'd0, 19'h00777, 8'h5A, 1'b0, c, e, t);
        check(e && !t, "R7", "verify mismatch flagged", {e, t}, 2'b10);
    endtask

    task automatic t_sector_erase;
        int c; logic e, t;
        model_setup(3, 1'b0, 8'hFF);
        run_req(2'd1, 19'h3C400, 8'h00, 1'b0, c, e, t);
        check(wr_cnt == 6, "R2", "sector write count", wr_cnt, 6);
        check(wl_d[2] == 8'h80 && wl_a[3] == 19'h05555 && wl_d[3] == 8'hAA, "R2", "sector setup",
              wl_d[2], 8'h80);
        check(wl_a[4] == 19'h02AAA && wl_d[4] == 8'h55, "R2", "sector second unlock", wl_d[4], 8'h55);
        check(wl_a[5] == 19'h3C400 && wl_d[5] == 8'h30, "R2", "sector final", wl_d[5], 8'h30);
        check(rd_cnt == 4, "R5", "erase polls against FFh", rd_cnt, 4);
        check(!e && !t, "R5", "sector flags", {e, t}, 0);
    endtask

    task automatic t_chip_erase;
        int c; logic e, t;
        model_setup(1, 1'b0, 8'hFF);
        run_req(2'd2, 19'h00010, 8'h00, 1'b0, c, e, t);
        check(wr_cnt == 6, "R3", "chip write count", wr_cnt, 6);
        check(wl_a[5] == 19'h05555 && wl_d[5] == 8'h10, "R3", "chip final", wl_d[5], 8'h10);
        check(!e && !t, "R3", "chip flags", {e, t}, 0);
    endtask

    task automatic t_reset_cmd;
        int c; logic e, t;
        model_setup(0, 1'b0, 8'hFF);
        run_req(2'd3, 19'h00abc, 8'h00, 1'b0, c, e, t);
        check(wr_cnt == 1 && wl_d[0] == 8'hF0 && wl_a[0] == 19'h00abc, "R4", "reset write",
              wl_d[0], 8'hF0);
        check(rd_cnt == 0 && !e && !t, "R4", "reset no reads", rd_cnt, 0);
    endtask

    task automatic t_toggle;
        int c; logic e, t;
        // stored byte has bit7 different from data: polling would never end
        model_setup(5, 1'b0, 8'h3A);
        run_req(2'd0, 19'h00100, 8'hBA, 1'b1, c, e, t);
        check(!t && !e, "R6", "toggle completes", {e, t}, 0);
        check(rd_cnt >= 6 && rd_cnt <= 7, "R6", "toggle read count", rd_cnt, 6);
    endtask

    task automatic t_timeouts;
        int c; logic e, t;
        model_setup(0, 1'b1, 8'h11);
        run_req(2'd0, 19'h00200, 8'h11, 1'b0, c, e, t);
        check(t && !e, "R8", "program timeout flag", {e, t}, 2'b01);
        check(c >= TP + 5 && c <= TP + 18, "R8", "program timeout window", c, TP + 10);
        model_setup(0, 1'b1, 8'hFF);
        run_req(2'd1, 19'h00400, 8'h00, 1'b1, c, e, t);
        check(t, "R8", "sector timeout flag", t, 1);
        check(c >= TS + 5 && c <= TS + 18, "R8", "sector timeout window", c, TS + 14);
        model_setup(0, 1'b1, 8'hFF);
        run_req(2'd2, 19'h00000, 8'h00, 1'b0, c, e, t);
        check(t, "R8", "chip timeout flag", t, 1);
        check(c >= TC + 5 && c <= TC + 18, "R8", "chip timeout window", c, TC + 14);
    endtask

    task automatic t_busy_gate;
        int cyc;
        model_setup(4, 1'b0, 8'h66);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 19'h00300; req_data = 8'h66; req_toggle = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !req_ready, "R10", "busy after accept", {busy, req_ready}, 2'b10);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 19'h00999;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_done && cyc < 5000) begin
            check(busy, "R10", "busy held until done", busy, 1);
            @(negedge clk);
            cyc++;
        end
        check(busy, "R10", "busy during done", busy, 1);
        @(negedge clk);
        check(!rsp_done && !busy, "R10", "done single pulse", {rsp_done, busy}, 0);
        repeat (6) @(negedge clk);
        check(wr_cnt == 4, "R9", "request while busy dropped", wr_cnt, 4);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_program_poll();
        t_program_verify_fail();
        t_sector_erase();
        t_chip_erase();
        t_reset_cmd();
        t_toggle();
        t_timeouts();
        t_busy_gate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule